// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

This block is a small processor that works on 24-bit words. It runs each instruction as a short sequence of states over a byte-wide synchronous memory port. Every instruction is one 24-bit word. Every data word is three bytes, and the most significant byte sits at the lowest address. The core holds five registers:

- an accumulator
- an index register
- a linkage register
- a program counter
- a status word

The program counter is as wide as the 15-bit byte address space. The other four registers are 24 bits wide.

Subroutine calls store the return address in the linkage register, and no stack is used. Device I/O moves one byte between the low eight bits of the accumulator and a device chosen by an 8-bit code. The code is the low byte of the instruction's address field. A program polls a device with the test instruction and then reads or writes one byte.

The memory samples `mem_addr` on each rising edge and returns that byte on `mem_rdata` one cycle later. It writes `mem_wdata` when `mem_we` is high. The status word is visible on a port.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the outputs are at rest: `mem_addr`=0, `mem_we`=0, `dev_test`=`dev_rd`=`dev_wr`=0, `status_word`=0. The program counter restarts at `RESET_PC` (0).
- R2: An instruction is read as three byte cycles at PC, PC+1 and PC+2 and assembled big-endian. Its layout is opcode in bits 23..16, x flag in bit 15 and address field in bits 14..0. After the fetch the PC has grown by 3.
- R3: The target address is the address field plus, when x=1, the low 15 bits of the index register, modulo 32768. The upper index bits play no part.
- R4: Word loads read three bytes at target, target+1 and target+2, with the MSB first. Stores write three bytes at consecutive addresses, with the MSB at the target. The load opcodes are 00 (accumulator), 04 (index) and 08 (linkage). The store opcodes are 0C (accumulator), 10 (index) and 14 (linkage).
- R5: The accumulator arithmetic opcodes are 18 (add), 1C (subtract) and 20 (multiply). Each one replaces the accumulator with the low 24 bits of the two's complement result of accumulator op memory word.
- R6: Opcode 24 divides the accumulator by the memory word as signed values, truncating toward zero. A zero divisor leaves the accumulator unchanged and sets status bit 2. That bit stays set until reset.
- R7: Compare (opcode 28) sets status bits 1..0 from a signed comparison of the accumulator against the memory word: 00 less, 01 equal, 10 greater. The accumulator is not changed.
- R8: Opcode 38 jumps when the code is 00, opcode 30 when it is 01, and opcode 34 when it is 10. Opcode 3C always jumps. An untaken jump falls through to the next word.
- R9: Opcode 48 stores the address of the following instruction in the linkage register and jumps to the target. Opcode 4C jumps to the address held in the linkage register.
- R10: Opcode E0 pulses `dev_test` for one cycle with `dev_code` set to the field's low byte. The status code becomes 00 if `dev_ready` is high and 01 if it is low.
- R11: Opcode D8 pulses `dev_rd` and loads `dev_rdata` into accumulator bits 7..0, leaving bits 23..8 unchanged. Opcode DC pulses `dev_wr` with accumulator bits 7..0 on `dev_wdata`. At most one of `dev_test`, `dev_rd`, `dev_wr` and `mem_we` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address for this cycle |
| mem_we | output | 1 | Write the byte on `mem_wdata` |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte addressed in the previous cycle |
| dev_code | output | 8 | Selected device |
| dev_test | output | 1 | Ready query strobe |
| dev_ready | input | 1 | Selected device is ready |
| dev_rd | output | 1 | Byte read strobe |
| dev_rdata | input | 8 | Byte from the device |
| dev_wr | output | 1 | Byte write strobe |
| dev_wdata | output | 8 | Byte to the device |
| status_word | output | 24 | Bits 1..0 condition code, bit 2 divide error |

## Verification
Faults in the fetch or target-address logic change the addresses on `mem_addr` within a cycle or two. They then show up as stores at the wrong place or as a program that never reaches its store. Faults in the ALU, byte ordering or linkage show only when a result word is stored. That store comes 8 to 20 cycles after the faulty step, so the bench reads the stored words back from its memory. Faults in the condition code or the divide-error bit appear on `status_word` the cycle after the compare, test or divide instruction. They also redirect the next conditional jump.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int WORD_W  = 24;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 15;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {ST_FETCH, ST_DEC, ST_RD, ST_EXE, ST_WR} state_e;

  localparam logic [7:0] OP_LDA  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h04;
  localparam logic [7:0] OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C;
  localparam logic [7:0] OP_STX  = 8'h10;
  localparam logic [7:0] OP_STL  = 8'h14;
  localparam logic [7:0] OP_ADD  = 8'h18;
  localparam logic [7:0] OP_SUB  = 8'h1C;
  localparam logic [7:0] OP_MUL  = 8'h20;
  localparam logic [7:0] OP_DIV  = 8'h24;
  localparam logic [7:0] OP_COMP = 8'h28;
  localparam logic [7:0] OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38;
  localparam logic [7:0] OP_J    = 8'h3C;
  localparam logic [7:0] OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_RD   = 8'hD8;
  localparam logic [7:0] OP_WD   = 8'hDC;
  localparam logic [7:0] OP_TD   = 8'hE0;

  localparam logic [1:0] CC_LT = 2'b00;
  localparam logic [1:0] CC_EQ = 2'b01;
  localparam logic [1:0] CC_GT = 2'b10;
  localparam int         ERR_BIT = 2;

  function automatic logic [1:0] f_cmp(word_t a, word_t b);
    if ($signed(a) < $signed(b)) return CC_LT;
    if (a == b) return CC_EQ;
    return CC_GT;
  endfunction

  function automatic word_t f_mul(word_t a, word_t b);
    return word_t'(a * b);
  endfunction

  // caller guarantees b != 0
  function automatic word_t f_div(word_t a, word_t b);
    return word_t'($signed(a) / $signed(b));
  endfunction

  function automatic logic f_reads_mem(logic [7:0] op);
    return op inside {OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB,
                      OP_MUL, OP_DIV, OP_COMP};
  endfunction

  function automatic logic f_writes_mem(logic [7:0] op);
    return op inside {OP_STA, OP_STX, OP_STL};
  endfunction
endpackage

// File: rtl/acc_addr.sv
module acc_addr
  import acc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               use_x,
  input  logic [ADDR_W-1:0]  idx_lo,
  output logic [ADDR_W-1:0]  ta
);
  assign ta = ADDR_W'(field) + (use_x ? idx_lo : '0);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  logic [7:0] op,
  input  word_t      a,
  input  word_t      b,
  output word_t      res,
  output logic [1:0] cc,
  output logic       dz
);
  always_comb begin
    res = a;
    dz  = 1'b0;
    unique case (op)
      OP_LDA: res = b;
      OP_ADD: res = a + b;
      OP_SUB: res = a - b;
      OP_MUL: res = f_mul(a, b);
      OP_DIV: begin
        if (b == '0) dz = 1'b1;
        else         res = f_div(a, b);
      end
      default: res = a;
    endcase
  end

  assign cc = f_cmp(a, b);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        dev_code,
  output logic              dev_test,
  input  logic              dev_ready,
  output logic              dev_rd,
  input  logic [7:0]        dev_rdata,
  output logic              dev_wr,
  output logic [7:0]        dev_wdata,
  output logic [23:0]       status_word
);
  localparam int PAD_W = WORD_W - ADDR_W;

  state_e            st_q;
  logic [1:0]        cnt_q;
  word_t             acc_q, idx_q, lnk_q, sw_q, ir_q, dr_q;
  logic [ADDR_W-1:0] pc_q, ta_q, ta_c, base;
  word_t             alu_res, st_src;
  logic [1:0]        alu_cc;
  logic              alu_dz;

  wire [7:0]         op    = ir_q[23:16];
  wire               xflag = ir_q[15];
  wire [FIELD_W-1:0] fld   = ir_q[FIELD_W-1:0];

  // named events for the checker
  wire fetch_done   = (st_q == ST_FETCH) && (cnt_q == 2'd3);
  wire div_zero_evt = (st_q == ST_EXE) && alu_dz && (op == OP_DIV);

  acc_addr #(.ADDR_W(ADDR_W)) u_addr (
    .field (fld),
    .use_x (xflag),
    .idx_lo(idx_q[ADDR_W-1:0]),
    .ta    (ta_c)
  );

  acc_alu u_alu (
    .op (op),
    .a  (acc_q),
    .b  (dr_q),
    .res(alu_res),
    .cc (alu_cc),
    .dz (alu_dz)
  );

  always_comb begin
    unique case (op)
      OP_STX:  st_src = idx_q;
      OP_STL:  st_src = lnk_q;
      default: st_src = acc_q;
    endcase
  end

  assign base      = (st_q == ST_FETCH) ? pc_q : ta_q;
  assign mem_addr  = base + ADDR_W'(cnt_q);
  assign mem_we    = (st_q == ST_WR);
  assign mem_wdata = (cnt_q == 2'd0) ? st_src[23:16] :
                     (cnt_q == 2'd1) ? st_src[15:8]  : st_src[7:0];

  assign dev_code    = fld[7:0];
  assign dev_test    = (st_q == ST_DEC) && (op == OP_TD);
  assign dev_rd      = (st_q == ST_DEC) && (op == OP_RD);
  assign dev_wr      = (st_q == ST_DEC) && (op == OP_WD);
  assign dev_wdata   = acc_q[7:0];
  assign status_word = sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_FETCH;
      cnt_q <= '0;
      pc_q  <= ADDR_W'(RESET_PC);
      ta_q  <= '0;
      acc_q <= '0;
      idx_q <= '0;
      lnk_q <= '0;
      sw_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_FETCH: begin
          if (cnt_q != 2'd0) ir_q <= {ir_q[15:0], mem_rdata};
          if (cnt_q == 2'd3) begin
            pc_q  <= pc_q + ADDR_W'(3);
            cnt_q <= '0;
            st_q  <= ST_DEC;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        ST_DEC: begin
          ta_q  <= ta_c;
          cnt_q <= '0;
          st_q  <= ST_FETCH;
          if (f_reads_mem(op))  st_q <= ST_RD;
          if (f_writes_mem(op)) st_q <= ST_WR;
          unique case (op)
            OP_J:    pc_q <= ta_c;
            OP_JLT:  if (sw_q[1:0] == CC_LT) pc_q <= ta_c;
            OP_JEQ:  if (sw_q[1:0] == CC_EQ) pc_q <= ta_c;
            OP_JGT:  if (sw_q[1:0] == CC_GT) pc_q <= ta_c;
            OP_JSUB: begin
              lnk_q <= {{PAD_W{1'b0}}, pc_q};
              pc_q  <= ta_c;
            end
            OP_RSUB: pc_q <= lnk_q[ADDR_W-1:0];
            OP_TD:   sw_q[1:0] <= dev_ready ? CC_LT : CC_EQ;
            OP_RD:   acc_q[7:0] <= dev_rdata;
            default: ;
          endcase
        end
        ST_RD: begin
          if (cnt_q != 2'd0) dr_q <= {dr_q[15:0], mem_rdata};
          if (cnt_q == 2'd3) begin
            cnt_q <= '0;
            st_q  <= ST_EXE;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        ST_EXE: begin
          unique case (op)
            OP_LDX:  idx_q <= dr_q;
            OP_LDL:  lnk_q <= dr_q;
            OP_COMP: sw_q[1:0] <= alu_cc;
            default: begin
              acc_q <= alu_res;
              if (alu_dz) sw_q[ERR_BIT] <= 1'b1;
            end
          endcase
          st_q <= ST_FETCH;
        end
        ST_WR: begin
          if (cnt_q == 2'd2) begin
            cnt_q <= '0;
            st_q  <= ST_FETCH;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pc_q,
  input logic              fetch_done,
  input logic              div_zero_evt,
  input logic [23:0]       acc_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              dev_test,
  input logic              dev_rd,
  input logic              dev_wr,
  input logic              dev_ready,
  input logic [23:0]       status_word
);
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(3)));

  a_r4_store_run: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    status_word[2] |=> status_word[2]);

  a_r6_dz_keep: assert property (@(posedge clk) disable iff (rst)
    div_zero_evt |=> (status_word[2] && acc_q == $past(acc_q)));

  a_r10_td_code: assert property (@(posedge clk) disable iff (rst)
    dev_test |=> status_word[1:0] == ($past(dev_ready) ? 2'b00 : 2'b01));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_test, dev_rd, dev_wr, mem_we}));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_q        (pc_q),
  .fetch_done  (fetch_done),
  .div_zero_evt(div_zero_evt),
  .acc_q       (acc_q),
  .mem_addr    (mem_addr),
  .mem_we      (mem_we),
  .dev_test    (dev_test),
  .dev_rd      (dev_rd),
  .dev_wr      (dev_wr),
  .dev_ready   (dev_ready),
  .status_word (status_word)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [14:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  dev_code, dev_wdata;
  logic        dev_test, dev_rd, dev_wr;
  logic        dev_ready = 1'b0;
  logic [7:0]  dev_rdata = 8'h00;
  logic [23:0] status_word;

  acc_core u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_code(dev_code),
    .dev_test(dev_test), .dev_ready(dev_ready), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
    .status_word(status_word)
  );

  // bench opcodes, taken from the requirements
  localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, STA = 8'h0C, STL = 8'h14;
  localparam logic [7:0] ADD = 8'h18, SUB = 8'h1C, MUL = 8'h20, DIV = 8'h24;
  localparam logic [7:0] CMP = 8'h28, JEQ = 8'h30, JGT = 8'h34, JLT = 8'h38;
  localparam logic [7:0] JMP = 8'h3C, CALL = 8'h48, RET = 8'h4C;
  localparam logic [7:0] DRD = 8'hD8, DWR = 8'hDC, DTST = 8'hE0;

  logic [7:0] mem [0:4095];
  logic [7:0] rq;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    rq <= mem[mem_addr[11:0]];
  end
  assign mem_rdata = rq;

  int td_count = 0, wr_count = 0;
  logic [7:0] td_code = 0, wr_code = 0, wr_byte = 0;
  always @(posedge clk) begin
    if (dev_test) begin td_count <= td_count + 1; td_code <= dev_code; end
    if (dev_wr)   begin wr_count <= wr_count + 1; wr_code <= dev_code; wr_byte <= dev_wdata; end
  end

  int total = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] enc(input logic [7:0] op, input bit x, input logic [14:0] a);
    return {op, x, a};
  endfunction

  task automatic put(input int addr, input logic [23:0] w);
    mem[addr] = w[23:16]; mem[addr+1] = w[15:8]; mem[addr+2] = w[7:0];
  endtask

  function automatic logic [23:0] get(input int addr);
    return {mem[addr], mem[addr+1], mem[addr+2]};
  endfunction

  task automatic hold_clear();
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic go(input int cycles);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic longint sx(input logic [23:0] v);
    return v[23] ? longint'(v) - 64'sd16777216 : longint'(v);
  endfunction

  function automatic logic [23:0] exp_alu(input logic [7:0] op, input logic [23:0] a, input logic [23:0] b);
    longint r;
    case (op)
      ADD: r = sx(a) + sx(b);
      SUB: r = sx(a) - sx(b);
      MUL: r = longint'(a) * longint'(b);
      DIV: r = (b == 0) ? sx(a) : sx(a) / sx(b);
      default: r = sx(a);
    endcase
    return r[23:0];
  endfunction

  function automatic logic [1:0] exp_cc(input logic [23:0] a, input logic [23:0] b);
    if (sx(a) < sx(b)) return 2'b00;
    if (sx(a) == sx(b)) return 2'b01;
    return 2'b10;
  endfunction

  task automatic branch_case(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] m;
    hold_clear();
    put(0, enc(LDA, 0, 15'h300));  put(3, enc(CMP, 0, 15'h303));
    put(6, enc(JLT, 0, 15'h15));   put(9, enc(JEQ, 0, 15'h1B));
    put(12, enc(JGT, 0, 15'h21));  put(15, enc(JMP, 0, 15'h0F));
    put(21, enc(LDA, 0, 15'h330)); put(24, enc(JMP, 0, 15'h24));
    put(27, enc(LDA, 0, 15'h333)); put(30, enc(JMP, 0, 15'h24));
    put(33, enc(LDA, 0, 15'h336)); put(36, enc(STA, 0, 15'h306));
    put(39, enc(JMP, 0, 15'h27));
    put(12'h300, a); put(12'h303, b);
    put(12'h330, 24'h000111); put(12'h333, 24'h000222); put(12'h336, 24'h000333);
    go(120);
    m = (exp_cc(a, b) == 2'b00) ? 24'h000111 : (exp_cc(a, b) == 2'b01) ? 24'h000222 : 24'h000333;
    check(get(12'h306) == m, "R8 branch path", get(12'h306), m);
    check(status_word[1:0] == exp_cc(a, b), "R7 compare code", {22'd0, status_word[1:0]}, {22'd0, exp_cc(a, b)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=%06h expected=%06h", 24'd0, 24'd1);
    fails++; total++;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] ops[5];
    logic [23:0] a, b, e, got;
    void'($urandom(32'd20240611));
    ops[0] = ADD; ops[1] = SUB; ops[2] = MUL; ops[3] = DIV; ops[4] = CMP;

    // R1: reset state
    hold_clear();
    put(0, enc(JMP, 0, 15'h006));
    put(6, enc(JMP, 0, 15'h006));
    repeat (3) @(negedge clk);
    check(mem_addr == 0 && !mem_we, "R1 reset memory side", {9'd0, mem_addr}, 24'd0);
    check(!dev_test && !dev_rd && !dev_wr, "R1 reset device strobes", {21'd0, dev_test, dev_rd, dev_wr}, 24'd0);
    check(status_word == 0, "R1 reset status", status_word, 24'd0);

    // R2: fetch addresses, then PC + jump
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(mem_addr == 15'(k), "R2 fetch byte address", {9'd0, mem_addr}, 24'(k));
      @(negedge clk);
    end
    @(negedge clk); @(negedge clk);
    check(mem_addr == 15'h006, "R2/R8 next fetch at jump target", {9'd0, mem_addr}, 24'h6);

    // R5/R6/R7: random arithmetic
    for (int t = 0; t < 30; t++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 4)];
      a = 24'($urandom);
      b = ($urandom_range(0, 1) == 1) ? 24'($urandom) : 24'(sx(24'($urandom_range(0, 200))) - 100);
      if (t == 3) begin op = CMP; b = a; end
      if (op == DIV && b == 0) b = 24'd7;
      hold_clear();
      put(0, enc(LDA, 0, 15'h300)); put(3, enc(op, 0, 15'h303));
      put(6, enc(STA, 0, 15'h306)); put(9, enc(JMP, 0, 15'h009));
      put(12'h300, a); put(12'h303, b);
      go(50);
      e = exp_alu(op, a, b);
      got = get(12'h306);
      check(got == e, (op == CMP) ? "R7 compare keeps accumulator" :
                      (op == DIV) ? "R6 signed divide" : "R5 add/sub/mul", got, e);
      if (op == CMP)
        check(status_word[1:0] == exp_cc(a, b), "R7 compare code", {22'd0, status_word[1:0]}, {22'd0, exp_cc(a, b)});
      else
        check(status_word[2] == 1'b0, "R6 no error on nonzero divisor", {23'd0, status_word[2]}, 24'd0);
    end

    // R6: divide by zero
    hold_clear();
    put(0, enc(LDA, 0, 15'h300)); put(3, enc(DIV, 0, 15'h303));
    put(6, enc(STA, 0, 15'h306)); put(9, enc(ADD, 0, 15'h309));
    put(12, enc(STA, 0, 15'h30C)); put(15, enc(JMP, 0, 15'h00F));
    put(12'h300, 24'hF00123); put(12'h309, 24'h000001);
    go(80);
    check(get(12'h306) == 24'hF00123, "R6 zero divisor keeps accumulator", get(12'h306), 24'hF00123);
    check(get(12'h30C) == 24'hF00124, "R6 later add unaffected", get(12'h30C), 24'hF00124);
    check(status_word[2] == 1'b1, "R6 sticky error bit", {23'd0, status_word[2]}, 24'd1);

    // R3/R4: indexing and byte order
    hold_clear();
    put(0, enc(LDX, 0, 15'h300)); put(3, enc(LDA, 1, 15'h310));
    put(6, enc(STA, 1, 15'h320)); put(9, enc(JMP, 0, 15'h009));
    put(12'h300, 24'h018006); put(12'h316, 24'hA1B2C3); put(12'h310, 24'h111111);
    go(60);
    check(get(12'h326) == 24'hA1B2C3, "R3 indexed load and store", get(12'h326), 24'hA1B2C3);
    check(mem[12'h326] == 8'hA1 && mem[12'h328] == 8'hC3, "R4 big-endian store",
          {8'd0, mem[12'h326], mem[12'h328]}, 24'h00A1C3);
    check(get(12'h320) == 24'h0, "R3 unindexed slot untouched", get(12'h320), 24'h0);

    // R7/R8: branch paths
    branch_case(24'h000005, 24'h000009);
    branch_case(24'h123456, 24'h123456);
    branch_case(24'h000001, 24'hFFFFFF);
    branch_case(24'hFFFFFF, 24'h000001);

    // R9: call and return
    hold_clear();
    put(0, enc(CALL, 0, 15'h00C)); put(3, enc(STA, 0, 15'h306));
    put(6, enc(JMP, 0, 15'h006));
    put(12, enc(STL, 0, 15'h309)); put(15, enc(LDA, 0, 15'h300));
    put(18, enc(RET, 0, 15'h000));
    put(12'h300, 24'h5A5A5A);
    go(80);
    check(get(12'h309) == 24'h000003, "R9 return address in linkage", get(12'h309), 24'h3);
    check(get(12'h306) == 24'h5A5A5A, "R9 return resumes caller", get(12'h306), 24'h5A5A5A);

    // R10/R11: device polling and byte transfer
    hold_clear();
    dev_ready = 1'b0; dev_rdata = 8'hA5;
    put(0, enc(LDA, 0, 15'h300)); put(3, enc(DTST, 0, 15'h005));
    put(6, enc(JEQ, 0, 15'h003)); put(9, enc(DRD, 0, 15'h005));
    put(12, enc(DWR, 0, 15'h007)); put(15, enc(STA, 0, 15'h306));
    put(18, enc(JMP, 0, 15'h012));
    put(12'h300, 24'h123456);
    go(60);
    check(status_word[1:0] == 2'b01, "R10 busy device code", {22'd0, status_word[1:0]}, 24'h1);
    check(td_count > 0 && td_code == 8'h05, "R10 test strobe and code", {16'd0, td_code}, 24'h05);
    check(wr_count == 0, "R11 no write while busy", 24'(wr_count), 24'd0);
    @(negedge clk) dev_ready = 1'b1;
    repeat (80) @(negedge clk);
    check(status_word[1:0] == 2'b00, "R10 ready device code", {22'd0, status_word[1:0]}, 24'h0);
    check(get(12'h306) == 24'h1234A5, "R11 read into low byte", get(12'h306), 24'h1234A5);
    check(wr_count == 1 && wr_code == 8'h07 && wr_byte == 8'hA5, "R11 device write",
          {wr_code, wr_byte, 8'(wr_count)}, 24'h07A501);
    dev_ready = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule